// File: doc/BRIEF.md
# Banked Register File for a Two-Slot Long-Instruction-Word Datapath

This block holds the general registers of a datapath that issues one operation per slot each cycle, with two slots by default. It does not offer every port to every register. The register space is cut into banks, one bank per issue slot. Each bank has a single write port, and that port is tied to its own slot. As a result, a slot can retire its result only into its own bank. The bank is given by the upper bits of the register number and the entry within the bank by the lower bits.

Each slot presents a first operand number, a second operand number, a destination number, a write enable and the result data. The first operand must name a register in the slot's own bank. The second operand may name a register in any bank, so every bank carries one local read port plus one read port for each slot's second operand. With two slots that gives three read ports and one write port per bank. A value that is needed from a foreign bank in any other position must first be copied into the local bank by an earlier operation. If a slot asks to write while its destination or first operand lies outside its bank, the block raises an illegal-access flag for that slot and drops the write.

Top module: `vliw_banked_rf`

## Requirements
- R1: After reset every register in every bank reads as zero.
- R2: The bank of register number n is n >> log2(REGS_PER_BANK), and the entry within the bank is the low log2(REGS_PER_BANK) bits. Slot s owns bank s. A legal write, with write enable 1 and the destination and first operand both in bank s, stores the data at the next rising clock edge.
- R3: All slots can write in the same cycle, each into its own bank, for example registers 0 and 16 in the default setup.
- R4: The first-operand data is a combinational read of the slot's own bank. When the first operand names a register outside that bank, the first-operand data is zero.
- R5: The second-operand data is a combinational read of the named register in any bank.
- R6: The per-slot illegal flag is 1 in the same cycle exactly when the write enable is 1 and either the destination or the first operand lies outside the slot's bank.
- R7: A flagged write changes no register.
- R8: A read of a register written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R9: With the write enable at 0, no register changes.
- R10: Entry 0 of each bank is an ordinary register that stores any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_src_a | input | NUM_BANKS x IDX_W | Per-slot first operand register number (must be local) |
| slot_src_b | input | NUM_BANKS x IDX_W | Per-slot second operand register number (any bank) |
| slot_dst | input | NUM_BANKS x IDX_W | Per-slot destination register number |
| slot_we | input | NUM_BANKS | Per-slot write enable |
| slot_wdata | input | NUM_BANKS x DATA_W | Per-slot result data |
| slot_rd_a | output | NUM_BANKS x DATA_W | Per-slot first operand data |
| slot_rd_b | output | NUM_BANKS x DATA_W | Per-slot second operand data |
| slot_illegal | output | NUM_BANKS | Per-slot illegal-access flag |

## Verification
Operand data and illegal flags are combinational, so they are due in the same cycle as the inputs that produce them. A write becomes visible one cycle later, after the next rising edge. The bench changes inputs at the falling edge and samples 1 ns later, which compares reads against a model that still holds the old contents and so covers the no-bypass rule. The model is updated only after the rising edge. Dropped writes and ignored enables are observed through later second-operand reads, and a final sweep reads back every register.

// File: rtl/vliw_rf_pkg.sv
package vliw_rf_pkg;

  // Bank number that holds register idx, given the per-bank index width.
  function automatic int unsigned bank_of(input int unsigned idx, input int unsigned loc_w);
    return idx >> loc_w;
  endfunction

  // Entry within its bank of register idx.
  function automatic int unsigned local_of(input int unsigned idx, input int unsigned loc_w);
    return idx & ((32'd1 << loc_w) - 32'd1);
  endfunction

  // True when register idx lives in bank b.
  function automatic logic in_bank(input int unsigned idx, input int unsigned b,
                                   input int unsigned loc_w);
    return bank_of(idx, loc_w) == b;
  endfunction

endpackage

// File: rtl/rf_slot_check.sv
module rf_slot_check
  import vliw_rf_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LOC_W = 4,
  parameter int unsigned SLOT  = 0
) (
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] dst,
  input  logic             wr_en,
  output logic             a_local,
  output logic             illegal,
  output logic             do_write
);

  logic dst_local;

  always_comb begin
    a_local   = in_bank(int'(src_a), SLOT, LOC_W);
    dst_local = in_bank(int'(dst), SLOT, LOC_W);
    illegal   = wr_en && !(a_local && dst_local);
    do_write  = wr_en && a_local && dst_local;
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NRD    = 3,
  localparam int unsigned LOC_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [LOC_W-1:0]           widx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][LOC_W-1:0]  ridx,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Reads see the array before the edge: no write-to-read bypass.
  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata[p] = mem[ridx[p]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdata)); // R2

  for (genvar e = 0; e < int'(DEPTH); e++) begin : g_hold
    AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && widx == LOC_W'(e)) |=> $stable(mem[e])); // R9
  end

endmodule

// File: rtl/vliw_banked_rf.sv
module vliw_banked_rf
  import vliw_rf_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned REGS_PER_BANK = 16,
  parameter int unsigned DATA_W        = 32,
  localparam int unsigned LOC_W  = $clog2(REGS_PER_BANK),
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W  = LOC_W + BANK_W,
  localparam int unsigned NRD    = NUM_BANKS + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]  slot_src_a,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]  slot_src_b,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]  slot_dst,
  input  logic [NUM_BANKS-1:0]             slot_we,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] slot_wdata,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] slot_rd_a,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] slot_rd_b,
  output logic [NUM_BANKS-1:0]             slot_illegal
);

  logic [NUM_BANKS-1:0]                      bank_we;
  logic [NUM_BANKS-1:0]                      a_local;
  logic [NUM_BANKS-1:0][NRD-1:0][LOC_W-1:0]  bank_ridx;
  logic [NUM_BANKS-1:0][NRD-1:0][DATA_W-1:0] bank_rdata;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    rf_slot_check #(.IDX_W(IDX_W), .LOC_W(LOC_W), .SLOT(b)) i_check (
      .src_a    (slot_src_a[b]),
      .dst      (slot_dst[b]),
      .wr_en    (slot_we[b]),
      .a_local  (a_local[b]),
      .illegal  (slot_illegal[b]),
      .do_write (bank_we[b])
    );

    // Port 0 serves the owning slot's first operand; port 1+s serves slot s's second.
    assign bank_ridx[b][0] = LOC_W'(local_of(int'(slot_src_a[b]), LOC_W));
    for (genvar s = 0; s < int'(NUM_BANKS); s++) begin : g_port
      assign bank_ridx[b][1+s] = LOC_W'(local_of(int'(slot_src_b[s]), LOC_W));
    end

    rf_bank #(.DATA_W(DATA_W), .DEPTH(REGS_PER_BANK), .NRD(NRD)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[b]),
      .widx  (LOC_W'(local_of(int'(slot_dst[b]), LOC_W))),
      .wdata (slot_wdata[b]),
      .ridx  (bank_ridx[b]),
      .rdata (bank_rdata[b])
    );

    assign slot_rd_a[b] = a_local[b] ? bank_rdata[b][0] : '0;

    AST_FLAG_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_illegal[b] |-> slot_we[b]); // R6
    AST_FLAG_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_illegal[b] |-> !bank_we[b]); // R7
    AST_WRITE_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we[b] |-> bank_of(int'(slot_dst[b]), LOC_W) == b); // R2
  end

  // Second operand: cross-bank selection by the upper register bits.
  for (genvar s = 0; s < int'(NUM_BANKS); s++) begin : g_xsel
    logic [BANK_W-1:0] sel;
    assign sel          = BANK_W'(bank_of(int'(slot_src_b[s]), LOC_W));
    assign slot_rd_b[s] = bank_rdata[sel][1+s];
  end

endmodule

// File: tb/test_vliw_banked_rf.sv
`timescale 1ns/1ps
module test_vliw_banked_rf;

  localparam int NB = 2;
  localparam int NR = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0][4:0]  src_a, src_b, dst;
  logic [NB-1:0]       we;
  logic [NB-1:0][31:0] wdata;
  logic [NB-1:0][31:0] rd_a, rd_b;
  logic [NB-1:0]       ill;

  logic [31:0] mdl [NR];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vliw_banked_rf i_vliw_banked_rf (
    .clk(clk), .rst_n(rst_n), .slot_src_a(src_a), .slot_src_b(src_b),
    .slot_dst(dst), .slot_we(we), .slot_wdata(wdata),
    .slot_rd_a(rd_a), .slot_rd_b(rd_b), .slot_illegal(ill)
  );

  function automatic logic exp_ill(int s, logic [4:0] a, logic [4:0] d, logic e);
    return e && ((int'(d) / 16 != s) || (int'(a) / 16 != s));
  endfunction

  function automatic logic [31:0] exp_rda(int s, logic [4:0] a);
    return (int'(a) / 16 == s) ? mdl[a] : 32'd0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check combinational outputs, then update model.
  task automatic step(string tag,
                      logic [4:0] a0, logic [4:0] b0, logic [4:0] d0, logic e0, logic [31:0] w0,
                      logic [4:0] a1, logic [4:0] b1, logic [4:0] d1, logic e1, logic [31:0] w1);
    @(negedge clk);
    src_a[0] = a0; src_b[0] = b0; dst[0] = d0; we[0] = e0; wdata[0] = w0;
    src_a[1] = a1; src_b[1] = b1; dst[1] = d1; we[1] = e1; wdata[1] = w1;
    #1;
    for (int s = 0; s < NB; s++) begin
      chk(tag, $sformatf("rd_a[%0d]", s), rd_a[s], exp_rda(s, src_a[s]));
      chk(tag, $sformatf("rd_b[%0d]", s), rd_b[s], mdl[src_b[s]]);
      chk(tag, $sformatf("illegal[%0d]", s), 32'(ill[s]), 32'(exp_ill(s, src_a[s], dst[s], we[s])));
    end
    @(posedge clk);
    for (int s = 0; s < NB; s++)
      if (we[s] && !exp_ill(s, src_a[s], dst[s], we[s])) mdl[dst[s]] = wdata[s];
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] ra [NB];
    logic [4:0] rd [NB];
    logic [4:0] rb [NB];
    logic       re [NB];
    void'($urandom(32'd20517));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    src_a = '0; src_b = '0; dst = '0; we = '0; wdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset contents read as zero on both operand paths
    for (int i = 0; i < NR; i++)
      step("R1", 5'd0, 5'(i), 5'd16, 1'b0, 32'd0, 5'd16, 5'(NR - 1 - i), 5'd16, 1'b0, 32'd0);

    // R3 R10: both slots write entry 0 of their banks in one cycle; R8: old value read same cycle
    step("R3", 5'd0, 5'd0, 5'd0, 1'b1, 32'hA5A5_0001, 5'd16, 5'd16, 5'd16, 1'b1, 32'h5A5A_0002);
    step("R10", 5'd0, 5'd16, 5'd0, 1'b0, 32'd0, 5'd16, 5'd0, 5'd16, 1'b0, 32'd0);

    // R8: write register 3 while reading it, then read again
    step("R8", 5'd3, 5'd3, 5'd3, 1'b1, 32'hDEAD_BEEF, 5'd20, 5'd3, 5'd20, 1'b0, 32'd0);
    step("R8", 5'd3, 5'd3, 5'd3, 1'b0, 32'd0, 5'd20, 5'd3, 5'd20, 1'b0, 32'd0);

    // R6 R7: slot 0 writes into bank 1, slot 1 uses a foreign first operand
    step("R7", 5'd1, 5'd17, 5'd17, 1'b1, 32'h1111_1111, 5'd2, 5'd2, 5'd18, 1'b1, 32'h2222_2222);
    step("R7", 5'd1, 5'd17, 5'd1, 1'b0, 32'd0, 5'd18, 5'd18, 5'd18, 1'b0, 32'd0);
    step("R7", 5'd1, 5'd2, 5'd1, 1'b0, 32'd0, 5'd18, 5'd1, 5'd18, 1'b0, 32'd0);

    // R4: foreign first operand reads zero even without write enable
    step("R4", 5'd16, 5'd0, 5'd0, 1'b0, 32'd0, 5'd3, 5'd16, 5'd16, 1'b0, 32'd0);

    // R9: data present but enable low
    step("R9", 5'd4, 5'd4, 5'd4, 1'b0, 32'hFFFF_FFFF, 5'd21, 5'd21, 5'd21, 1'b0, 32'hFFFF_FFFF);
    step("R9", 5'd4, 5'd4, 5'd4, 1'b0, 32'd0, 5'd21, 5'd21, 5'd21, 1'b0, 32'd0);

    // R4 R5 R6: constrained random traffic, mostly legal
    for (int c = 0; c < 3000; c++) begin
      for (int s = 0; s < NB; s++) begin
        ra[s] = ($urandom % 10 != 0) ? 5'((s * 16) + ($urandom % 16)) : 5'($urandom % 32);
        rd[s] = ($urandom % 8 != 0) ? 5'((s * 16) + ($urandom % 16)) : 5'($urandom % 32);
        rb[s] = 5'($urandom % 32);
        re[s] = ($urandom % 4 != 0);
      end
      step("R4 R5 R6", ra[0], rb[0], rd[0], re[0], $urandom, ra[1], rb[1], rd[1], re[1], $urandom);
    end

    // R2: full readback of every register through the second operand path
    for (int i = 0; i < NR; i++)
      step("R2", 5'd0, 5'(i), 5'd0, 1'b0, 32'd0, 5'd16, 5'(NR - 1 - i), 5'd16, 1'b0, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule